// File: doc/BRIEF.md
# Spare Row Address Remapper

This block sits in front of the row decoder of a 514-row memory array (16 words per row, 8224 words in all). Each access presents a 14-bit word address; the upper ten bits select the row and the lower four select the word within the row. The block compares the row against four programmed spare-row registers. On a match it reports a hit and the number of the spare that takes over. It also raises a signal that keeps the normal wordline of that row from firing.

Rows 0 to 511 make up the lower bank and rows 512 and 513 make up the upper bank. Spares 0 and 1 belong to the lower bank and are programmed with a full 9-bit row number. Spares 2 and 3 belong to the upper bank and are programmed with one bit that picks row 512 (bit 0) or row 513 (bit 1). Every spare has its own active-high enable. The result is registered: an access presented with `req_vld` high at one rising edge appears on the outputs after that edge, together with `rsp_vld`.

Top module: `spare_row_remap`

## Requirements
- R1: One cycle after an edge with `req_vld` high, `rsp_vld` is 1 and `row_q` equals `addr[13:4]` from that edge; after an edge with `req_vld` low, `rsp_vld` is 0.
- R2: Lower-bank spare k (k = 0 or 1) hits when `bot_en[k]` is 1, the row is below 512 and the row equals `bot_row[9k+8:9k]`.
- R3: Upper-bank spare k (index 2+k) hits when `top_en[k]` is 1, the row is 512 or 513, and `top_sel[k]` equals the row minus 512.
- R4: A spare whose enable is 0 never hits, whatever its programmed address.
- R5: A lower-bank spare never hits rows 512 and above, and an upper-bank spare never hits rows below 512 or above 513. Rows 514 to 1023 never hit.
- R6: When more than one enabled spare matches, the lowest-numbered one is reported. `spare_idx` encodes 0 and 1 for the lower-bank spares and 2 and 3 for the upper-bank spares.
- R7: `main_wl_off` is 1 exactly when `spare_hit` is 1.
- R8: When no spare hits, `spare_idx` is 0.
- R9: While reset is held, `rsp_vld`, `spare_hit`, `main_wl_off`, `spare_idx` and `row_q` are all 0.
- R10: After an edge with `req_vld` low, `spare_hit`, `spare_idx`, `main_wl_off` and `row_q` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Access address valid |
| addr | input | 14 | Word address; bits 13:4 select the row |
| bot_en | input | 2 | Enables of the lower-bank spares |
| bot_row | input | 18 | Programmed rows of the lower-bank spares, 9 bits each, spare 0 in the low bits |
| top_en | input | 2 | Enables of the upper-bank spares |
| top_sel | input | 2 | Programmed row of each upper-bank spare (0 means 512, 1 means 513) |
| rsp_vld | output | 1 | Registered result valid |
| spare_hit | output | 1 | A spare row replaces the addressed row |
| spare_idx | output | 2 | Number of the spare that hit |
| main_wl_off | output | 1 | Suppress the normal wordline |
| row_q | output | 10 | Registered row number of the access |

## Verification
Every one of the 1024 values of the row field is swept under five spare programmings. With all spares disabled, any hit exposes a broken enable gate. A spread programming with one spare on each upper row separates the four comparators. Identical programmings in both lower spares and both upper spares show the priority order, and the same setting with the low spare disabled shows that the enable gates the priority. A programming at rows 0 and 511 checks that row 512, whose low nine bits equal 0, and the unused rows above 513 stay unmatched. A stretch of idle cycles after a hit shows that the outputs hold their values.

// File: rtl/srr_pkg.sv
package srr_pkg;

  // Which bank a decoded row belongs to.
  typedef enum logic [1:0] {
    BANK_BOT  = 2'd0,
    BANK_TOP  = 2'd1,
    BANK_NONE = 2'd2
  } bank_e;

endpackage

// File: rtl/srr_bank_decode.sv
module srr_bank_decode
  import srr_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int BOT_ROWS = 512,
  parameter int TOP_ROWS = 2
) (
  input  logic [ROW_W-1:0] row,
  output bank_e            bank
);

  localparam int TOP_END = BOT_ROWS + TOP_ROWS;

  always_comb begin
    if (32'(row) < BOT_ROWS) begin
      bank = BANK_BOT;
    end else if (32'(row) < TOP_END) begin
      bank = BANK_TOP;
    end else begin
      bank = BANK_NONE;
    end
  end

endmodule

// File: rtl/srr_spare_cmp.sv
module srr_spare_cmp #(
  parameter int KEY_W = 9
) (
  input  logic             en,
  input  logic             bank_ok,
  input  logic [KEY_W-1:0] prog,
  input  logic [KEY_W-1:0] key,
  output logic             match
);

  always_comb begin
    match = en && bank_ok && (prog == key);
  end

endmodule

// File: rtl/srr_pri_pick.sv
module srr_pri_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins: scan from the top down so lower indices overwrite.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        idx = IDX_W'(i);
      end
    end
    any = |hits;
  end

endmodule

// File: rtl/spare_row_remap.sv
module spare_row_remap
  import srr_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int COL_W    = 4,
  parameter int BOT_ROWS = 512,
  parameter int TOP_ROWS = 2,
  parameter int N_BOT    = 2,
  parameter int N_TOP    = 2,
  localparam int ROW_W   = ADDR_W - COL_W,
  localparam int BOT_AW  = $clog2(BOT_ROWS),
  localparam int TOP_AW  = (TOP_ROWS > 1) ? $clog2(TOP_ROWS) : 1,
  localparam int N_SP    = N_BOT + N_TOP,
  localparam int IDX_W   = (N_SP > 1) ? $clog2(N_SP) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_vld,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [N_BOT-1:0]        bot_en,
  input  logic [N_BOT*BOT_AW-1:0] bot_row,
  input  logic [N_TOP-1:0]        top_en,
  input  logic [N_TOP*TOP_AW-1:0] top_sel,
  output logic                    rsp_vld,
  output logic                    spare_hit,
  output logic [IDX_W-1:0]        spare_idx,
  output logic                    main_wl_off,
  output logic [ROW_W-1:0]        row_q
);

  // ---------------------------------------------------------------
  // Reset: asserted asynchronously, released on a clock edge.
  // ---------------------------------------------------------------
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe[1];

  // ---------------------------------------------------------------
  // Row extraction and bank decode
  // ---------------------------------------------------------------
  logic [ROW_W-1:0] row_in;
  logic [ROW_W-1:0] top_off;
  logic             unused_col;
  bank_e            bank;
  logic             in_bot;
  logic             in_top;

  assign row_in     = addr[ADDR_W-1:COL_W];
  assign unused_col = ^addr[COL_W-1:0];
  assign top_off    = row_in - ROW_W'(BOT_ROWS);

  srr_bank_decode #(
    .ROW_W   (ROW_W),
    .BOT_ROWS(BOT_ROWS),
    .TOP_ROWS(TOP_ROWS)
  ) u_bank (
    .row (row_in),
    .bank(bank)
  );

  assign in_bot = (bank == BANK_BOT);
  assign in_top = (bank == BANK_TOP);

  // ---------------------------------------------------------------
  // One comparator per spare; lower bank first, then upper bank
  // ---------------------------------------------------------------
  logic [N_SP-1:0] hits;

  for (genvar g = 0; g < N_BOT; g++) begin : g_bot
    srr_spare_cmp #(.KEY_W(BOT_AW)) u_cmp (
      .en     (bot_en[g]),
      .bank_ok(in_bot),
      .prog   (bot_row[g*BOT_AW +: BOT_AW]),
      .key    (row_in[BOT_AW-1:0]),
      .match  (hits[g])
    );
  end

  for (genvar g = 0; g < N_TOP; g++) begin : g_top
    srr_spare_cmp #(.KEY_W(TOP_AW)) u_cmp (
      .en     (top_en[g]),
      .bank_ok(in_top),
      .prog   (top_sel[g*TOP_AW +: TOP_AW]),
      .key    (top_off[TOP_AW-1:0]),
      .match  (hits[N_BOT+g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  srr_pri_pick #(.N(N_SP)) u_pick (
    .hits(hits),
    .any (any_hit),
    .idx (win_idx)
  );

  // ---------------------------------------------------------------
  // Next state
  // ---------------------------------------------------------------
  logic             vld_d;
  logic             hit_d;
  logic             wl_d;
  logic [IDX_W-1:0] idx_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    vld_d = req_vld;
    hit_d = spare_hit;
    wl_d  = main_wl_off;
    idx_d = spare_idx;
    row_d = row_q;
    if (req_vld) begin
      hit_d = any_hit;
      wl_d  = any_hit;
      idx_d = win_idx;
      row_d = row_in;
    end
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_vld <= 1'b0;
    end else begin
      rsp_vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      spare_hit   <= 1'b0;
      main_wl_off <= 1'b0;
      spare_idx   <= '0;
      row_q       <= '0;
    end else begin
      spare_hit   <= hit_d;
      main_wl_off <= wl_d;
      spare_idx   <= idx_d;
      row_q       <= row_d;
    end
  end

endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int ADDR_W   = 14,
  parameter int COL_W    = 4,
  parameter int BOT_ROWS = 512,
  parameter int TOP_ROWS = 2,
  parameter int N_BOT    = 2,
  parameter int N_TOP    = 2,
  localparam int ROW_W   = ADDR_W - COL_W,
  localparam int BOT_AW  = $clog2(BOT_ROWS),
  localparam int N_SP    = N_BOT + N_TOP,
  localparam int IDX_W   = (N_SP > 1) ? $clog2(N_SP) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_vld,
  input logic [ADDR_W-1:0]       addr,
  input logic [N_BOT-1:0]        bot_en,
  input logic [N_BOT*BOT_AW-1:0] bot_row,
  input logic [N_TOP-1:0]        top_en,
  input logic                    rsp_vld,
  input logic                    spare_hit,
  input logic [IDX_W-1:0]        spare_idx,
  input logic                    main_wl_off,
  input logic [ROW_W-1:0]        row_q
);

  logic [ROW_W-1:0] row_in;
  assign row_in = addr[ADDR_W-1:COL_W];

  assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  assert_vld_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  assert_row_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (row_q == $past(row_in)));

  assert_bot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_hit && (32'(spare_idx) < N_BOT)) |-> (32'(row_q) < BOT_ROWS));

  assert_top_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_hit && (32'(spare_idx) >= N_BOT)) |->
      ((32'(row_q) >= BOT_ROWS) && (32'(row_q) < BOT_ROWS + TOP_ROWS)));

  assert_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (bot_en == '0) && (top_en == '0)) |=> !spare_hit);

  assert_high_rows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (32'(row_in) >= BOT_ROWS + TOP_ROWS)) |=> !spare_hit);

  assert_first_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && bot_en[0] && (32'(row_in) == 32'(bot_row[BOT_AW-1:0])))
      |=> (spare_hit && (spare_idx == '0)));

  assert_wl_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spare_hit |-> main_wl_off);

  assert_wl_off_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !spare_hit |-> !main_wl_off);

  assert_idx_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !spare_hit |-> (spare_idx == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(row_q) && $stable(spare_hit) && $stable(spare_idx)));

endmodule

bind spare_row_remap srr_checker #(
  .ADDR_W  (ADDR_W),
  .COL_W   (COL_W),
  .BOT_ROWS(BOT_ROWS),
  .TOP_ROWS(TOP_ROWS),
  .N_BOT   (N_BOT),
  .N_TOP   (N_TOP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .req_vld    (req_vld),
  .addr       (addr),
  .bot_en     (bot_en),
  .bot_row    (bot_row),
  .top_en     (top_en),
  .rsp_vld    (rsp_vld),
  .spare_hit  (spare_hit),
  .spare_idx  (spare_idx),
  .main_wl_off(main_wl_off),
  .row_q      (row_q)
);

// File: tb/sim_spare_row_remap.sv
module sim_spare_row_remap;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic [13:0] addr;
  logic [1:0]  bot_en;
  logic [17:0] bot_row;
  logic [1:0]  top_en;
  logic [1:0]  top_sel;
  logic        rsp_vld;
  logic        spare_hit;
  logic [1:0]  spare_idx;
  logic        main_wl_off;
  logic [9:0]  row_q;

  int total;
  int bad;

  // programmed spare configuration as seen by the bench
  int fa0, fa1;
  bit e0, e1, te0, te1, s0, s1;

  spare_row_remap u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .addr       (addr),
    .bot_en     (bot_en),
    .bot_row    (bot_row),
    .top_en     (top_en),
    .top_sel    (top_sel),
    .rsp_vld    (rsp_vld),
    .spare_hit  (spare_hit),
    .spare_idx  (spare_idx),
    .main_wl_off(main_wl_off),
    .row_q      (row_q)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit a0, input bit a1, input int f0, input int f1,
                     input bit b0, input bit b1, input bit t0, input bit t1);
    e0 = a0; e1 = a1; fa0 = f0; fa1 = f1;
    te0 = b0; te1 = b1; s0 = t0; s1 = t1;
    bot_en  = {a1, a0};
    bot_row = {9'(f1), 9'(f0)};
    top_en  = {b1, b0};
    top_sel = {t1, t0};
  endtask

  // Expected result from the requirements (R2, R3, R5, R6)
  task automatic expect_of(input int row, output bit h, output int idx);
    h = 1'b0;
    idx = 0;
    if (row < 512) begin
      if (e0 && fa0 == row) begin h = 1'b1; idx = 0; end
      else if (e1 && fa1 == row) begin h = 1'b1; idx = 1; end
    end else if (row < 514) begin
      if (te0 && int'(s0) == row - 512) begin h = 1'b1; idx = 2; end
      else if (te1 && int'(s1) == row - 512) begin h = 1'b1; idx = 3; end
    end
  endtask

  // Present one access at a falling edge, check at the next falling edge.
  task automatic access(input int row, input string tag);
    bit h;
    int idx;
    req_vld = 1'b1;
    addr    = {10'(row), 4'(row * 7)};
    @(negedge clk);
    expect_of(row, h, idx);
    chk(rsp_vld == 1'b1 && int'(row_q) == row, "R1 row/valid", int'(row_q), row);
    chk(spare_hit == h && int'(spare_idx) == idx,
        h ? tag : {tag, " R8"}, {spare_hit, 8'(spare_idx)}, {h, 8'(idx)});
    chk(main_wl_off == spare_hit, "R7 wordline", main_wl_off, spare_hit);
  endtask

  task automatic sweep(input string tag);
    for (int r = 0; r < 1024; r++) begin
      access(r, tag);
    end
  endtask

  initial begin
    total   = 0;
    bad     = 0;
    rst_n   = 1'b0;
    req_vld = 1'b0;
    addr    = '0;
    cfg(1, 1, 3, 4, 1, 1, 0, 1);
    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset is held, even with a pending request
    req_vld = 1'b1;
    @(negedge clk);
    chk(rsp_vld == 0 && spare_hit == 0 && main_wl_off == 0 && spare_idx == 0 && row_q == 0,
        "R9 reset", {rsp_vld, spare_hit, main_wl_off, 2'(spare_idx), 10'(row_q)}, 0);
    req_vld = 1'b0;
    rst_n   = 1'b1;
    repeat (4) @(negedge clk);

    // R4: every spare disabled, addresses still programmed
    cfg(0, 0, 5, 300, 0, 0, 1, 0);
    sweep("R4 disabled");

    // R2 R3: four distinct targets
    cfg(1, 1, 5, 300, 1, 1, 1, 0);
    sweep("R2 R3 spread");

    // R6: both lower spares on row 77, both upper spares on row 512
    cfg(1, 1, 77, 77, 1, 1, 0, 0);
    sweep("R6 priority");

    // R4 R6: low spare of each pair disabled, higher one takes the row
    cfg(0, 1, 77, 77, 0, 1, 1, 1);
    sweep("R4 R6 gated priority");

    // R5: lower spares at the bank edges; row 512 must not alias row 0
    cfg(1, 1, 0, 511, 0, 1, 0, 0);
    sweep("R5 bank bounds");

    // R10: hit on row 511 then idle with a different address
    access(511, "R5 bank bounds");
    req_vld = 1'b0;
    addr    = {10'd0, 4'd0};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_vld == 1'b0, "R1 idle valid", rsp_vld, 0);
      chk(spare_hit == 1'b1 && spare_idx == 2'd1 && main_wl_off == 1'b1 && row_q == 10'd511,
          "R10 hold", {spare_hit, 2'(spare_idx), 10'(row_q)}, {1'b1, 2'd1, 10'd511});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule